// File: doc/BRIEF.md
# Autobaud Serial Boot Sequencer

This block loads a boot image over a plain asynchronous serial line without knowing the host's bit rate beforehand. After reset it keeps its transmit pin idle and undriven and waits for the host to send a byte of all zeros. It times how long the receive line stays low across that byte: the start bit plus eight zero data bits, nine bit periods in all. A timer that advances once every `PRESCALE` clocks does the timing.

The raw measurement goes out on a port so that other logic can compute divisor values from it. Internally the block takes the count divided by nine as the bit length in timer ticks. With that bit length it enables its driver, returns a fixed identification byte, receives a fixed number of payload bytes and writes each one through a byte-write strobe. It then pulses a completion flag and stays inert until the next reset.

If the line is still low when the timer reaches its ceiling, the block reports an error. It then waits for the line to return high and for a new start edge before it measures again.

Top module: `autobaud_boot_seq`

## Requirements
- R1: Out of reset `txd_o` is 1, `txd_oe_o` is 0, `wr_en_o` and `done_o` are 0, and `meas_cnt_o` is 0.
- R2: After the zero byte, `meas_cnt_o` equals the number of synchronised low cycles divided by `PRESCALE`, rounded down, which is 9·fclk/(PRESCALE·baud). The value then stays constant until reset.
- R3: `txd_oe_o` stays 0 while the zero byte is being received. It becomes 1 only after the line goes high at the zero byte's stop bit, and then stays 1.
- R4: After the measurement the block sends `ID_BYTE` (default 8'hA5). The frame is one low start bit, eight data bits least significant first and one high stop bit. Each bit lasts floor(`meas_cnt_o`/9)·`PRESCALE` clocks.
- R5: Each byte received after the identification byte is sampled at its bit centres, least significant bit first. It appears on `wr_data_o` with `wr_en_o` high for one cycle. Addresses run from 0 upward in steps of 1 to `PAYLOAD_BYTES`-1.
- R6: `done_o` is high for exactly one cycle, the cycle after the write to address `PAYLOAD_BYTES`-1.
- R7: After `done_o`, traffic on `rxd_i` causes no writes and no further `done_o`, and `txd_o` stays 1.
- R8: If the line is still low when the measurement timer is at its maximum and a further tick arrives, `meas_err_o` pulses for one cycle and `txd_oe_o` stays 0. `meas_cnt_o` keeps its value. A later complete zero byte is then measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line from the host (asynchronous) |
| txd_o | output | 1 | Serial transmit data, 1 when idle |
| txd_oe_o | output | 1 | Transmit driver enable |
| meas_cnt_o | output | CNT_W | Captured zero-byte duration in prescaled ticks |
| meas_err_o | output | 1 | One-cycle pulse when the measurement timer saturated |
| wr_addr_o | output | $clog2(PAYLOAD_BYTES) | Payload buffer write address |
| wr_data_o | output | 8 | Payload byte being written |
| wr_en_o | output | 1 | Payload write strobe |
| done_o | output | 1 | One-cycle pulse after the last payload write |

## Verification
The bench targets the exact measured count at two bit rates. An off-by-one in starting the prescaler, or counting the edge-detect cycle twice, would show up there as 143 or 145 instead of 144. It samples the identification byte at the centres implied by the measured bit length, so a wrong divide or a missing prescale shift would return garbage bits. It drives a low that outlasts the saturated timer, which catches a wrapping counter, a driver enabled too early, or a block that never re-arms. It also sends bytes after completion, so a sequencer that keeps writing or wraps its address to 0 would be flagged by the scoreboard.

// File: rtl/abs_pkg.sv
package abs_pkg;
   typedef enum logic [1:0] {PH_MEAS, PH_SEND, PH_LOAD, PH_DONE} phase_e;
   typedef enum logic [1:0] {MS_IDLE, MS_LOW, MS_WAIT_HI} meas_st_e;
   typedef enum logic [1:0] {RS_IDLE, RS_START, RS_DATA, RS_STOP} rx_st_e;
endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b1;
            else if (s == 0) chain[s] <= d_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/abs_meas.sv
module abs_meas
   import abs_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             rx_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             valid_o,
   output logic             err_o
);
   localparam int PRE_W = $clog2(PRESCALE);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   meas_st_e         st;
   logic [PRE_W-1:0] pre;
   logic [CNT_W-1:0] run;
   logic             rx_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= MS_IDLE;
         pre     <= '0;
         run     <= '0;
         rx_prev <= 1'b1;
         cnt_o   <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         rx_prev <= rx_i;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
         unique case (st)
            MS_IDLE: if (en_i && rx_prev && !rx_i) begin
               pre <= PRE_W'(1);
               run <= '0;
               st  <= MS_LOW;
            end
            MS_LOW: begin
               if (rx_i) begin
                  cnt_o   <= run;
                  valid_o <= 1'b1;
                  st      <= MS_IDLE;
               end else if (pre == PRE_LAST) begin
                  pre <= '0;
                  if (run == CNT_MAX) begin
                     err_o <= 1'b1;
                     st    <= MS_WAIT_HI;
                  end else begin
                     run <= run + 1'b1;
                  end
               end else begin
                  pre <= pre + 1'b1;
               end
            end
            MS_WAIT_HI: if (rx_i) st <= MS_IDLE;
            default: st <= MS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/abs_tx.sv
module abs_tx #(
   parameter int BIT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [7:0]       data_i,
   input  logic [BIT_W-1:0] bit_clks_i,
   output logic             txd_o,
   output logic             done_o
);
   logic [9:0]       sh;
   logic [3:0]       nbits;
   logic [BIT_W-1:0] tmr;
   logic             busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '1;
         nbits  <= '0;
         tmr    <= '0;
         busy   <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !busy) begin
            sh    <= {1'b1, data_i, 1'b0};
            nbits <= '0;
            tmr   <= bit_clks_i - 1'b1;
            busy  <= 1'b1;
         end else if (busy) begin
            if (tmr == '0) begin
               if (nbits == 4'd9) begin
                  busy   <= 1'b0;
                  done_o <= 1'b1;
               end else begin
                  sh    <= {1'b1, sh[9:1]};
                  nbits <= nbits + 1'b1;
                  tmr   <= bit_clks_i - 1'b1;
               end
            end else begin
               tmr <= tmr - 1'b1;
            end
         end
      end
   end

   assign txd_o = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/abs_rx.sv
module abs_rx
   import abs_pkg::*;
#(
   parameter int BIT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             rx_i,
   input  logic [BIT_W-1:0] bit_clks_i,
   output logic             valid_o,
   output logic [7:0]       data_o
);
   rx_st_e           st;
   logic [BIT_W-1:0] tmr;
   logic [2:0]       nbit;
   logic [BIT_W-1:0] half;

   assign half = bit_clks_i >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RS_IDLE;
         tmr     <= '0;
         nbit    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         unique case (st)
            RS_IDLE: if (en_i && !rx_i) begin
               tmr <= half - 1'b1;
               st  <= RS_START;
            end
            RS_START: begin
               if (tmr != '0) tmr <= tmr - 1'b1;
               else if (rx_i) st <= RS_IDLE;
               else begin
                  tmr  <= bit_clks_i - 1'b1;
                  nbit <= '0;
                  st   <= RS_DATA;
               end
            end
            RS_DATA: begin
               if (tmr != '0) tmr <= tmr - 1'b1;
               else begin
                  data_o <= {rx_i, data_o[7:1]};
                  tmr    <= bit_clks_i - 1'b1;
                  nbit   <= nbit + 1'b1;
                  if (nbit == 3'd7) st <= RS_STOP;
               end
            end
            RS_STOP: begin
               if (tmr != '0) tmr <= tmr - 1'b1;
               else begin
                  valid_o <= 1'b1;
                  st      <= RS_IDLE;
               end
            end
            default: st <= RS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/autobaud_boot_seq.sv
module autobaud_boot_seq
   import abs_pkg::*;
#(
   parameter int         CNT_W         = 16,
   parameter int         PRESCALE      = 4,
   parameter int         FRAME_BITS    = 9,
   parameter int         PAYLOAD_BYTES = 32,
   parameter int         SYNC_STAGES   = 2,
   parameter logic [7:0] ID_BYTE       = 8'hA5,
   localparam int        ADDR_W        = $clog2(PAYLOAD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_i,
   output logic              txd_o,
   output logic              txd_oe_o,
   output logic [CNT_W-1:0]  meas_cnt_o,
   output logic              meas_err_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_en_o,
   output logic              done_o
);
   localparam int PRE_W = $clog2(PRESCALE);
   localparam int BIT_W = CNT_W + PRE_W;
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAYLOAD_BYTES - 1);

   generate
      if (PRESCALE < 2 || (PRESCALE & (PRESCALE - 1)) != 0) begin : g_bad_pre
         $error("PRESCALE must be a power of two, at least 2");
      end
      if (PAYLOAD_BYTES < 2) begin : g_bad_len
         $error("PAYLOAD_BYTES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must be at least 8");
      end
   endgenerate

   phase_e           phase;
   logic             rx_s;
   logic             m_valid;
   logic [CNT_W-1:0] quot;
   logic [BIT_W-1:0] bit_clks;
   logic             tx_start, tx_done;
   logic             rx_valid;
   logic [7:0]       rx_byte;
   logic [ADDR_W-1:0] idx;

   abs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s));

   abs_meas #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_meas (
      .clk(clk), .rst_n(rst_n), .en_i(phase == PH_MEAS), .rx_i(rx_s),
      .cnt_o(meas_cnt_o), .valid_o(m_valid), .err_o(meas_err_o));

   abs_tx #(.BIT_W(BIT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .start_i(tx_start), .data_i(ID_BYTE),
      .bit_clks_i(bit_clks), .txd_o(txd_o), .done_o(tx_done));

   abs_rx #(.BIT_W(BIT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en_i(phase == PH_LOAD), .rx_i(rx_s),
      .bit_clks_i(bit_clks), .valid_o(rx_valid), .data_o(rx_byte));

   assign quot = meas_cnt_o / CNT_W'(FRAME_BITS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_MEAS;
         bit_clks  <= '0;
         tx_start  <= 1'b0;
         txd_oe_o  <= 1'b0;
         idx       <= '0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
         done_o    <= 1'b0;
      end else begin
         tx_start <= 1'b0;
         wr_en_o  <= 1'b0;
         done_o   <= wr_en_o && (wr_addr_o == LAST_ADDR);
         unique case (phase)
            PH_MEAS: if (m_valid) begin
               bit_clks <= {quot, {PRE_W{1'b0}}};
               tx_start <= 1'b1;
               txd_oe_o <= 1'b1;
               phase    <= PH_SEND;
            end
            PH_SEND: if (tx_done) phase <= PH_LOAD;
            PH_LOAD: if (rx_valid) begin
               wr_en_o   <= 1'b1;
               wr_addr_o <= idx;
               wr_data_o <= rx_byte;
               idx       <= idx + 1'b1;
               if (idx == LAST_ADDR) phase <= PH_DONE;
            end
            default: phase <= PH_DONE;
         endcase
      end
   end
endmodule

// File: rtl/abs_boot_chk.sv
module abs_boot_chk #(
   parameter int CNT_W         = 16,
   parameter int PAYLOAD_BYTES = 32,
   localparam int ADDR_W       = $clog2(PAYLOAD_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              txd_o,
   input logic              txd_oe_o,
   input logic [CNT_W-1:0]  meas_cnt_o,
   input logic              meas_err_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic              wr_en_o,
   input logic              done_o
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAYLOAD_BYTES - 1);

   logic [ADDR_W-1:0] exp_addr;
   logic              seen_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_addr  <= '0;
         seen_done <= 1'b0;
      end else begin
         if (wr_en_o) exp_addr <= exp_addr + 1'b1;
         if (done_o) seen_done <= 1'b1;
      end
   end

   p_line_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !txd_oe_o |-> txd_o);
   p_cnt_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txd_oe_o |=> $stable(meas_cnt_o));
   p_oe_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      txd_oe_o |=> txd_oe_o);
   p_addr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> wr_addr_o == exp_addr);
   p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(wr_en_o) && $past(wr_addr_o) == LAST_ADDR);
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_quiet_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_done |-> !wr_en_o && !done_o);
   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      meas_err_o |=> !meas_err_o);
   p_err_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      meas_err_o |-> !txd_oe_o);
endmodule

bind autobaud_boot_seq abs_boot_chk #(
   .CNT_W(CNT_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .txd_o(txd_o), .txd_oe_o(txd_oe_o),
   .meas_cnt_o(meas_cnt_o), .meas_err_o(meas_err_o), .wr_addr_o(wr_addr_o),
   .wr_en_o(wr_en_o), .done_o(done_o)
);

// File: tb/test_autobaud_boot_seq.sv
module test_autobaud_boot_seq;
   localparam int CNT_W = 10;
   localparam int NBYTES = 32;
   localparam int AW = $clog2(NBYTES);
   localparam logic [7:0] ID = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rxd = 1'b1;
   logic txd, txd_oe, m_err, wr_en, done;
   logic [CNT_W-1:0] m_cnt;
   logic [AW-1:0] wr_addr;
   logic [7:0] wr_data;

   int n_tests = 0, n_fail = 0;
   int done_cnt = 0, err_cnt = 0;
   bit finished = 0;
   logic prev_wr = 0;
   logic [AW-1:0] prev_addr = '0;
   logic [AW+7:0] sb_q[$];

   always #10 clk = ~clk;

   autobaud_boot_seq #(.CNT_W(CNT_W), .PAYLOAD_BYTES(NBYTES), .ID_BYTE(ID)) i_autobaud_boot_seq (
      .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .txd_o(txd), .txd_oe_o(txd_oe),
      .meas_cnt_o(m_cnt), .meas_err_o(m_err), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_en_o(wr_en), .done_o(done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (sb_q.size() == 0) check(0, "R7 unexpected write", int'(wr_addr), -1);
            else begin
               logic [AW+7:0] e;
               e = sb_q.pop_front();
               check({wr_addr, wr_data} == e, "R5 payload write", int'({wr_addr, wr_data}), int'(e));
            end
         end
         if (done) begin
            done_cnt++;
            check(prev_wr && prev_addr == AW'(NBYTES - 1), "R6 done after last write",
                  int'(prev_addr), NBYTES - 1);
         end
         if (m_err) err_cnt++;
         prev_wr   <= wr_en;
         prev_addr <= wr_addr;
      end
   end

   task automatic send_byte(input logic [7:0] b, input int p, input bit push, input int addr);
      if (push) sb_q.push_back({AW'(addr), b});
      rxd = 1'b0;
      repeat (p) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         rxd = b[k];
         repeat (p) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (p) @(negedge clk);
   endtask

   task automatic send_zero(input int p);
      rxd = 1'b0;
      repeat (p * 9 / 2) @(negedge clk);
      check(txd_oe == 1'b0, "R3 no drive mid zero byte", txd_oe, 0);
      repeat (p * 9 - p * 9 / 2) @(negedge clk);
      check(txd_oe == 1'b0, "R3 no drive before stop edge", txd_oe, 0);
      rxd = 1'b1;
   endtask

   task automatic get_id(input int p);
      logic [7:0] got;
      int guard;
      guard = 0;
      while (txd && guard < 20 * p) begin
         @(negedge clk);
         guard++;
      end
      check(txd_oe == 1'b1, "R3 driver enabled after zero byte", txd_oe, 1);
      repeat (p / 2) @(negedge clk);
      check(txd == 1'b0, "R4 start bit", txd, 0);
      for (int k = 0; k < 8; k++) begin
         repeat (p) @(negedge clk);
         got[k] = txd;
      end
      repeat (p) @(negedge clk);
      check(txd == 1'b1, "R4 stop bit", txd, 1);
      check(got == ID, "R4 identification byte", got, ID);
      repeat (p) @(negedge clk);
   endtask

   task automatic run_load(input int p, input logic [7:0] seed);
      for (int i = 0; i < NBYTES; i++)
         send_byte(seed ^ 8'(i * 37), p, 1, i);
      repeat (4 * p) @(negedge clk);
      check(sb_q.size() == 0, "R5 all payload bytes written", sb_q.size(), 0);
      check(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(txd == 1 && txd_oe == 0 && wr_en == 0 && done == 0 && m_cnt == 0,
            "R1 reset state", {txd, txd_oe, wr_en, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // run 1: bit period 64 clocks -> 576 low cycles -> 144 ticks
      send_zero(64);
      repeat (4) @(negedge clk);
      check(m_cnt == 144, "R2 count at 64-clock bits", m_cnt, 144);
      get_id(64);
      check(m_cnt == 144, "R2 count holds", m_cnt, 144);
      run_load(64, 8'h3C);
      for (int i = 0; i < 3; i++) send_byte(8'h5A + 8'(i), 64, 0, 0);
      repeat (200) @(negedge clk);
      check(done_cnt == 1 && txd == 1, "R7 ignored after done", done_cnt, 1);

      // run 2: saturation, then bit period 40 clocks -> 90 ticks
      rst_n = 1'b0;
      done_cnt = 0;
      err_cnt = 0;
      sb_q.delete();
      rxd = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      rxd = 1'b0;
      repeat (5000) @(negedge clk);
      rxd = 1'b1;
      repeat (200) @(negedge clk);
      check(err_cnt == 1, "R8 one error pulse", err_cnt, 1);
      check(txd_oe == 0 && txd == 1, "R8 no drive after error", txd_oe, 0);
      check(m_cnt == 0, "R8 count unchanged", m_cnt, 0);
      send_zero(40);
      repeat (4) @(negedge clk);
      check(m_cnt == 90, "R8 R2 re-measure at 40-clock bits", m_cnt, 90);
      get_id(40);
      run_load(40, 8'hC7);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule